// File: doc/BRIEF.md
# Prioritized Interrupt Level Resolver

This block collects interrupt events into a pending register, qualifies them with a software-written enable register, and reports the most urgent interrupt level that may currently be taken. Each level owns a bit mask that selects which lines belong to it. The resolver walks the levels from the top one downward. It stops when it finds a level whose mask meets the enabled pending lines. It only considers levels strictly above the level the processor is already running at, and it reports the chosen level number together with a request flag.

Interrupt lines arrive as events. A direct event names an internal line by index. An external event names an external interrupt number, which a configuration table translates into an internal line. Each line is either level-type or edge-type. A level-type line loses its pending bit when its source is deasserted. An edge-type line keeps its pending bit until software clears it through a write-one-to-clear port.

The resolver holds two states. `RES_IDLE` means no request is raised. `RES_REQ` means a request is raised. The transition `RES_IDLE -> RES_REQ` is taken when the scan finds a qualifying level. The transition `RES_REQ -> RES_IDLE` is taken when the scan finds none. In every other case the state holds. The level output is registered in the same cycle as the state.

Top module: `irq_level_resolver`

## Requirements
- R1: After reset the pending register, the enable register, `irq_level`, `irq_req` and `ext_reject` are all zero.
- R2: A direct event with `set_valid`=1, `set_active`=1 and `set_idx` below NUM_LINES sets pending bit `set_idx`. The bit is visible on `pending_o` after the next clock edge.
- R3: A deassert event (`set_active`=0 or `ext_active`=0) clears the named pending bit only when `line_type` for that line is 0 (level-type). When `line_type` is 1 (edge-type), the bit stays set.
- R4: A direct event whose `set_idx` is NUM_LINES or more changes nothing. The same holds for an external event whose table entry is NUM_LINES or more.
- R5: An external event with `ext_num`=k below NUM_EXT acts as a direct event on line `ext_map[k*IDX_W +: IDX_W]`. When k is NUM_EXT or more, the event is rejected: the pending register is unchanged and `ext_reject` is 1 for the following cycle only.
- R6: When `clr_wr` is 1, every pending bit whose `clr_data` bit is 1 is cleared. A set event on the same line in the same cycle wins over the clear.
- R7: When `en_wr` is 1, the whole enable register is replaced by `en_wdata`. Only pending bits that are also enabled take part in the scan.
- R8: Level L (1..NUM_LEVELS) uses mask `level_mask[(L-1)*NUM_LINES +: NUM_LINES]`. One cycle after the inputs, `irq_level` shows the highest such L that qualifies, and `irq_req` is 1.
- R9: When no level qualifies, `irq_level` is 0 and `irq_req` is 0 one cycle later.
- R10: A level qualifies only when it is strictly greater than `cur_level`. Pending lines at or below `cur_level` never raise a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_type | input | NUM_LINES | Per line: 1 = edge-type, 0 = level-type |
| set_valid | input | 1 | Direct line event strobe |
| set_idx | input | IDX_W | Internal line addressed by the direct event |
| set_active | input | 1 | 1 = line asserted, 0 = line deasserted |
| ext_valid | input | 1 | External interrupt event strobe |
| ext_num | input | EXT_W | External interrupt number |
| ext_active | input | 1 | 1 = external line asserted, 0 = deasserted |
| ext_map | input | NUM_EXT*IDX_W | External-number-to-line table, entry k at bits k*IDX_W |
| clr_wr | input | 1 | Write-one-to-clear strobe for pending bits |
| clr_data | input | NUM_LINES | Bits to clear |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | NUM_LINES | New enable register value |
| cur_level | input | LVL_W | Current processor interrupt level |
| level_mask | input | NUM_LEVELS*NUM_LINES | Per-level line masks, level L at bits (L-1)*NUM_LINES |
| pending_o | output | NUM_LINES | Pending register |
| irq_level | output | LVL_W | Registered highest qualifying level, 0 if none |
| irq_req | output | 1 | Registered interrupt request |
| ext_reject | output | 1 | One-cycle flag for an out-of-range external number |

## Verification
The scan is tested with three pending patterns: one line per level, several levels pending at once, and lines pending only at or below `cur_level`. Together they separate a top-down priority pick from a bottom-up one and from a comparison that is not strict. Deassert events are sent to both line types, which shows whether the clear is gated by line type. The out-of-range direct indices, the external table entry that points past the last line, and the out-of-range external numbers show that range checks sit on both paths. A long pseudo-random run then mixes set, deassert, clear, enable and level changes in the same cycles, which checks that a set takes priority over a clear.

// File: rtl/irq_res_pkg.sv
package irq_res_pkg;

    typedef enum logic [0:0] {
        RES_IDLE = 1'b0,
        RES_REQ  = 1'b1
    } res_state_e;

endpackage

// File: rtl/irq_pend_reg.sv
module irq_pend_reg #(
    parameter int NUM_LINES = 8,
    parameter int IDX_W     = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_type,
    input  logic                 ev0_valid,
    input  logic [IDX_W-1:0]     ev0_idx,
    input  logic                 ev0_active,
    input  logic                 ev1_valid,
    input  logic [IDX_W-1:0]     ev1_idx,
    input  logic                 ev1_active,
    input  logic                 clr_wr,
    input  logic [NUM_LINES-1:0] clr_data,
    input  logic                 en_wr,
    input  logic [NUM_LINES-1:0] en_wdata,
    output logic [NUM_LINES-1:0] pend_q,
    output logic [NUM_LINES-1:0] en_q
);

    // One slice per line; an index that matches no slice touches nothing.
    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        logic hit0;
        logic hit1;
        logic set_b;
        logic lvl_clr_b;
        logic w1c_b;
        logic next_b;

        always_comb begin
            hit0      = ev0_valid && (ev0_idx == IDX_W'(g));
            hit1      = ev1_valid && (ev1_idx == IDX_W'(g));
            set_b     = (hit0 && ev0_active) || (hit1 && ev1_active);
            lvl_clr_b = ((hit0 && !ev0_active) || (hit1 && !ev1_active)) && !line_type[g];
            w1c_b     = clr_wr && clr_data[g];
            next_b    = set_b || (pend_q[g] && !lvl_clr_b && !w1c_b);
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend_q[g] <= 1'b0;
            end else begin
                pend_q[g] <= next_b;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (en_wr) begin
            en_q <= en_wdata;
        end
    end

endmodule

// File: rtl/irq_ext_map.sv
module irq_ext_map #(
    parameter int NUM_EXT = 4,
    parameter int EXT_W   = 3,
    parameter int IDX_W   = 4
) (
    input  logic                     ext_valid,
    input  logic [EXT_W-1:0]         ext_num,
    input  logic [NUM_EXT*IDX_W-1:0] ext_map,
    output logic                     line_valid,
    output logic [IDX_W-1:0]         line_idx,
    output logic                     reject
);

    logic in_range;

    always_comb begin
        in_range = int'(ext_num) < NUM_EXT;
        line_idx = '0;
        for (int k = 0; k < NUM_EXT; k++) begin
            if (int'(ext_num) == k) begin
                line_idx = ext_map[k*IDX_W +: IDX_W];
            end
        end
        line_valid = ext_valid && in_range;
        reject     = ext_valid && !in_range;
    end

endmodule

// File: rtl/irq_level_scan.sv
module irq_level_scan #(
    parameter int NUM_LINES  = 8,
    parameter int NUM_LEVELS = 3,
    parameter int LVL_W      = 2
) (
    input  logic [NUM_LINES-1:0]            pend,
    input  logic [NUM_LINES-1:0]            en,
    input  logic [LVL_W-1:0]                cur_level,
    input  logic [NUM_LEVELS*NUM_LINES-1:0] level_mask,
    output logic                            found,
    output logic [LVL_W-1:0]                level
);

    logic [NUM_LINES-1:0]  eff;
    logic [NUM_LEVELS:1]   hit;

    assign eff = pend & en;

    for (genvar l = 1; l <= NUM_LEVELS; l++) begin : g_lvl
        logic above;
        logic any;
        always_comb begin
            above    = int'(cur_level) < l;
            any      = |(level_mask[(l-1)*NUM_LINES +: NUM_LINES] & eff);
            hit[l]   = above && any;
        end
    end

    // Ascending walk: the last hit written is the highest level.
    always_comb begin
        level = '0;
        for (int l = 1; l <= NUM_LEVELS; l++) begin
            if (hit[l]) begin
                level = LVL_W'(l);
            end
        end
        found = |hit;
    end

endmodule

// File: rtl/irq_level_resolver.sv
module irq_level_resolver
    import irq_res_pkg::*;
#(
    parameter int  NUM_LINES  = 8,
    parameter int  IDX_W      = 4,
    parameter int  NUM_LEVELS = 3,
    parameter int  NUM_EXT    = 4,
    parameter int  EXT_W      = 3,
    localparam int LVL_W      = $clog2(NUM_LEVELS + 1)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_LINES-1:0]            line_type,
    input  logic                            set_valid,
    input  logic [IDX_W-1:0]                set_idx,
    input  logic                            set_active,
    input  logic                            ext_valid,
    input  logic [EXT_W-1:0]                ext_num,
    input  logic                            ext_active,
    input  logic [NUM_EXT*IDX_W-1:0]        ext_map,
    input  logic                            clr_wr,
    input  logic [NUM_LINES-1:0]            clr_data,
    input  logic                            en_wr,
    input  logic [NUM_LINES-1:0]            en_wdata,
    input  logic [LVL_W-1:0]                cur_level,
    input  logic [NUM_LEVELS*NUM_LINES-1:0] level_mask,
    output logic [NUM_LINES-1:0]            pending_o,
    output logic [LVL_W-1:0]                irq_level,
    output logic                            irq_req,
    output logic                            ext_reject
);

    logic                 map_valid;
    logic [IDX_W-1:0]     map_idx;
    logic                 map_reject;
    logic [NUM_LINES-1:0] pend_q;
    logic [NUM_LINES-1:0] en_q;
    logic                 scan_found;
    logic [LVL_W-1:0]     scan_level;

    res_state_e           state_q;
    res_state_e           state_d;
    logic [LVL_W-1:0]     level_q;
    logic                 reject_q;

    irq_ext_map #(
        .NUM_EXT (NUM_EXT),
        .EXT_W   (EXT_W),
        .IDX_W   (IDX_W)
    ) u_map (
        .ext_valid  (ext_valid),
        .ext_num    (ext_num),
        .ext_map    (ext_map),
        .line_valid (map_valid),
        .line_idx   (map_idx),
        .reject     (map_reject)
    );

    irq_pend_reg #(
        .NUM_LINES (NUM_LINES),
        .IDX_W     (IDX_W)
    ) u_pend (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_type  (line_type),
        .ev0_valid  (set_valid),
        .ev0_idx    (set_idx),
        .ev0_active (set_active),
        .ev1_valid  (map_valid),
        .ev1_idx    (map_idx),
        .ev1_active (ext_active),
        .clr_wr     (clr_wr),
        .clr_data   (clr_data),
        .en_wr      (en_wr),
        .en_wdata   (en_wdata),
        .pend_q     (pend_q),
        .en_q       (en_q)
    );

    irq_level_scan #(
        .NUM_LINES  (NUM_LINES),
        .NUM_LEVELS (NUM_LEVELS),
        .LVL_W      (LVL_W)
    ) u_scan (
        .pend       (pend_q),
        .en         (en_q),
        .cur_level  (cur_level),
        .level_mask (level_mask),
        .found      (scan_found),
        .level      (scan_level)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= RES_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RES_IDLE: if (scan_found)  state_d = RES_REQ;
            RES_REQ:  if (!scan_found) state_d = RES_IDLE;
            default:  state_d = RES_IDLE;
        endcase
    end

    // Registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_q  <= '0;
            reject_q <= 1'b0;
        end else begin
            level_q  <= scan_found ? scan_level : '0;
            reject_q <= map_reject;
        end
    end

    assign pending_o  = pend_q;
    assign irq_level  = level_q;
    assign irq_req    = (state_q == RES_REQ);
    assign ext_reject = reject_q;

endmodule

// File: rtl/irq_level_resolver_chk.sv
module irq_level_resolver_chk #(
    parameter int NUM_LINES = 8,
    parameter int IDX_W     = 4,
    parameter int NUM_EXT   = 4,
    parameter int EXT_W     = 3,
    parameter int LVL_W     = 2
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [NUM_LINES-1:0] line_type,
    input logic                 set_valid,
    input logic [IDX_W-1:0]     set_idx,
    input logic                 set_active,
    input logic                 ext_valid,
    input logic [EXT_W-1:0]     ext_num,
    input logic                 clr_wr,
    input logic [LVL_W-1:0]     cur_level,
    input logic [NUM_LINES-1:0] pending_o,
    input logic [LVL_W-1:0]     irq_level,
    input logic                 irq_req
);

    localparam int LW = $clog2(NUM_LINES);

    assert_set_line_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (set_valid && set_active && int'(set_idx) < NUM_LINES)
        |=> pending_o[$past(set_idx[LW-1:0])]);

    assert_edge_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (set_valid && !set_active && int'(set_idx) < NUM_LINES &&
         line_type[set_idx[LW-1:0]] && !clr_wr && !ext_valid)
        |=> pending_o[$past(set_idx[LW-1:0])] == $past(pending_o[set_idx[LW-1:0]]));

    assert_bad_idx_ignored_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (set_valid && int'(set_idx) >= NUM_LINES && !ext_valid && !clr_wr)
        |=> $stable(pending_o));

    assert_ext_reject_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_valid && int'(ext_num) >= NUM_EXT && !set_valid && !clr_wr)
        |=> $stable(pending_o));

    assert_req_has_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> irq_level != '0);

    assert_idle_level_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_req |-> irq_level == '0);

    assert_strictly_above_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> irq_level > $past(cur_level));

endmodule

bind irq_level_resolver irq_level_resolver_chk #(
    .NUM_LINES (NUM_LINES),
    .IDX_W     (IDX_W),
    .NUM_EXT   (NUM_EXT),
    .EXT_W     (EXT_W),
    .LVL_W     (LVL_W)
) u_chk (.*);

// File: tb/irq_level_resolver_bench.sv
module irq_level_resolver_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NL   = 8;
    localparam int IW   = 4;
    localparam int NLV  = 3;
    localparam int NE   = 4;
    localparam int EW   = 3;
    localparam int LW   = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [NL-1:0]    line_type;
    logic             set_valid;
    logic [IW-1:0]    set_idx;
    logic             set_active;
    logic             ext_valid;
    logic [EW-1:0]    ext_num;
    logic             ext_active;
    logic [NE*IW-1:0] ext_map;
    logic             clr_wr;
    logic [NL-1:0]    clr_data;
    logic             en_wr;
    logic [NL-1:0]    en_wdata;
    logic [LW-1:0]    cur_level;
    logic [NLV*NL-1:0] level_mask;
    logic [NL-1:0]    pending_o;
    logic [LW-1:0]    irq_level;
    logic             irq_req;
    logic             ext_reject;

    irq_level_resolver u_irq_level_resolver (
        .clk, .rst_n, .line_type, .set_valid, .set_idx, .set_active,
        .ext_valid, .ext_num, .ext_active, .ext_map, .clr_wr, .clr_data,
        .en_wr, .en_wdata, .cur_level, .level_mask,
        .pending_o, .irq_level, .irq_req, .ext_reject
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int    n_checks = 0;
    int    n_fails  = 0;
    bit    finished = 0;
    string phase    = "R1";

    // Behavioural reference
    bit [NL-1:0] m_pend;
    bit [NL-1:0] m_en;
    int          e_level;
    bit          e_req;
    bit          e_rej;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pend = '0; m_en = '0; e_level = 0; e_req = 0; e_rej = 0;
        end else begin
            bit [NL-1:0] setm;
            bit [NL-1:0] clrm;
            int lv;
            lv = 0;
            for (int l = NLV; l > int'(cur_level); l--)
                if (lv == 0 && ((level_mask[(l-1)*NL +: NL] & m_pend & m_en) != 0)) lv = l;
            e_level = lv;
            e_req   = (lv != 0);
            e_rej   = ext_valid && int'(ext_num) >= NE;
            setm = '0; clrm = '0;
            if (clr_wr) clrm = clr_data;
            if (set_valid && int'(set_idx) < NL) begin
                if (set_active) setm[set_idx] = 1'b1;
                else if (!line_type[set_idx]) clrm[set_idx] = 1'b1;
            end
            if (ext_valid && int'(ext_num) < NE) begin
                int li;
                li = int'(ext_map[int'(ext_num)*IW +: IW]);
                if (li < NL) begin
                    if (ext_active) setm[li] = 1'b1;
                    else if (!line_type[li]) clrm[li] = 1'b1;
                end
            end
            m_pend = (m_pend & ~clrm) | setm;
            if (en_wr) m_en = en_wdata;
        end
    end

    task automatic compare();
        n_checks++;
        if (pending_o !== m_pend || int'(irq_level) != e_level ||
            irq_req !== e_req || ext_reject !== e_rej) begin
            n_fails++;
            $display("FAIL %s: pend=%h/%h level=%0d/%0d req=%0b/%0b rej=%0b/%0b",
                     phase, pending_o, m_pend, irq_level, e_level,
                     irq_req, e_req, ext_reject, e_rej);
        end
    endtask

    task automatic quiet();
        set_valid = 0; ext_valid = 0; clr_wr = 0; en_wr = 0;
        set_active = 0; ext_active = 0;
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
        compare();
        quiet();
    endtask

    task automatic line_ev(input int idx, input bit act);
        set_valid = 1; set_idx = IW'(idx); set_active = act;
        step();
    endtask

    task automatic ext_ev(input int k, input bit act);
        ext_valid = 1; ext_num = EW'(k); ext_active = act;
        step();
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        n_fails++;
        $display("FAIL watchdog: run did not complete");
        finish_run();
    end

    initial begin
        bit [31:0] lfsr;
        line_type  = 8'b1001_0010;         // lines 1,4,7 edge-type
        level_mask = {8'hC0, 8'h38, 8'h07}; // L3: 6,7  L2: 3,4,5  L1: 0,1,2
        ext_map    = {4'd12, 4'd7, 4'd5, 4'd2};
        cur_level  = '0; clr_data = '0; en_wdata = '0;
        set_idx = '0; ext_num = '0;
        quiet();
        repeat (3) @(negedge clk);
        // R1 reset state
        phase = "R1"; compare();
        rst_n = 1;
        step();

        phase = "R7"; en_wr = 1; en_wdata = 8'hFF; step();
        phase = "R2"; line_ev(0, 1); step();          // level 1
        phase = "R8"; line_ev(3, 1); step();          // level 2
        line_ev(6, 1); step();                        // level 3
        phase = "R10"; cur_level = 2; step();         // still 3
        phase = "R3"; line_ev(6, 0); step();          // level-type clears
        phase = "R10"; step(); cur_level = 1; step(); cur_level = 3; step(); step();
        cur_level = 0; step();
        phase = "R3"; line_ev(7, 1); line_ev(7, 0); step(); // edge keeps
        phase = "R6"; clr_wr = 1; clr_data = 8'h80; step(); step();
        clr_wr = 1; clr_data = 8'h09; set_valid = 1; set_idx = 0; set_active = 1; step(); step();
        phase = "R4"; line_ev(9, 1); line_ev(15, 1); line_ev(8, 0); step();
        phase = "R5"; ext_ev(1, 1); ext_ev(3, 1); ext_ev(5, 1); step();
        ext_ev(7, 1); ext_ev(0, 1); ext_ev(0, 0); ext_ev(2, 1); ext_ev(2, 0); step();
        phase = "R7"; en_wr = 1; en_wdata = 8'h07; step(); step();
        phase = "R9"; en_wr = 1; en_wdata = 8'h00; step(); step();
        clr_wr = 1; clr_data = 8'hFF; step(); en_wr = 1; en_wdata = 8'hFF; step(); step();

        phase = "R8 random";
        lfsr = 32'h1ACE_B00C;
        for (int i = 0; i < 600; i++) begin
            lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
            set_valid  = lfsr[0];
            set_idx    = lfsr[4:1];
            set_active = lfsr[5] | lfsr[6];
            ext_valid  = lfsr[7] & lfsr[8];
            ext_num    = lfsr[11:9];
            ext_active = lfsr[12];
            clr_wr     = lfsr[13] & lfsr[14] & lfsr[15];
            clr_data   = lfsr[23:16];
            en_wr      = (lfsr[27:24] == 4'h0);
            en_wdata   = lfsr[31:24] | 8'h5A;
            if (lfsr[28] & lfsr[29]) cur_level = lfsr[31:30];
            step();
        end
        finish_run();
    end

endmodule